// File: doc/BRIEF.md
# Data-Processing Execute Stage with Status Writeback

This block is the arithmetic and logic execute stage of a 32-bit processor core. Each issued operation carries a 4-bit operation code, a first operand and a second operand that an upstream shifter has already prepared. It also carries the shifter's carry-out, a set-flags bit, the destination register index and the saved status word of the current mode. One clock edge after issue, the block presents the result, a register-file write enable, a status-restore strobe and a pipeline-refill request.

The status word lives inside the block. The four condition flags sit in its top four bits: N at bit W-1, Z at W-2, C at W-3 and V at W-4. The lower bits change only when the whole word is reloaded from the saved copy. The current carry, taken from this register, feeds the carry-using operations.

Destination index 15 is the program counter. A write to it requests a pipeline refill. When such a write also has the set-flags bit, the whole status word is reloaded from the saved copy instead of updating the flags. A compare-type operation that names index 15 reloads the status word and does nothing else.

Top module: `dpu_exec`

## Requirements
- R1: Operation codes map to 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, A CMP, B CMN, C ORR, D MOV (copy second operand), E BIC (first AND NOT second), F MVN (NOT second). res_o shows the result on the cycle after valid_i.
- R2: RSB computes second minus first. RSC is SBC with the two operands exchanged.
- R3: For ADD, ADC and CMN the carry is bit W of left+right+cin, where cin is the current C for ADC and 0 otherwise. V is bit W-1 of (left^res)&(right^res).
- R4: For SUB, RSB, SBC, RSC and CMP, a (W+1)-bit subtrahend equals right-cin+1, where cin is the current C for SBC/RSC and 1 otherwise. The result is left minus the subtrahend. C is set when subtrahend<=left. V is bit W-1 of (left^res)&(~right^res).
- R5: TST, TEQ, CMP and CMN never assert wr_en_o. They update the flags whether or not set_i is high.
- R6: Logic operations (AND, EOR, TST, TEQ, ORR, MOV, BIC, MVN) that update flags take N and Z from the result and C from shc_i, and leave V unchanged.
- R7: For every flag update, N is result bit W-1 and Z is set exactly when the result is zero. With set_i low, non-test operations leave the status word unchanged.
- R8: A non-test operation with destination 15 and set_i high writes the result, loads the status word from saved_i, and asserts restore_o and refill_o for one cycle.
- R9: A test operation with destination 15 loads the status word from saved_i and asserts restore_o. It asserts neither wr_en_o nor refill_o.
- R10: A non-test operation with destination 15 and set_i low writes the result and asserts refill_o. The status word is unchanged and restore_o stays low.
- R11: After reset, res_o, the status word and all strobes are zero.
- R12: In a cycle without valid_i, the following cycle has all strobes low and the status word and res_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation issued this cycle |
| op_i | input | 4 | Operation code |
| opa_i | input | W | First operand |
| opb_i | input | W | Shifted second operand |
| shc_i | input | 1 | Shifter carry-out |
| set_i | input | 1 | Set-flags bit |
| rd_i | input | RIDX_W | Destination register index |
| saved_i | input | W | Saved status word |
| res_o | output | W | Registered result |
| wr_en_o | output | 1 | Destination write enable |
| restore_o | output | 1 | Status word reloaded from saved copy |
| refill_o | output | 1 | Pipeline refill request |
| stat_o | output | W | Status word, NZCV in top four bits |

## Verification
On every cycle, the assertions check the control side. They check that a reload copies the saved word and raises the strobe, and that compare-type operations never write. They also check that refill follows any write to index 15, that V survives logic updates, that set_i low leaves the status word alone, and that an idle cycle is quiet. The arithmetic values are shown only by the bench's scenarios. These values are the sums and differences, the 33-bit subtrahend corner where the second operand is all ones and carry is clear, and the effect of the carry-in on ADC, SBC and RSC.

// File: rtl/dpu_pkg.sv
package dpu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } dp_op_e;

  typedef enum logic [1:0] {CLS_LOGIC, CLS_ADD, CLS_SUB} dp_cls_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/dpu_decode.sv
module dpu_decode
  import dpu_pkg::*;
(
  input  logic [3:0] op_i,
  output dp_cls_e    cls_o,
  output logic       swap_o,
  output logic       use_c_o,
  output logic       test_o
);
  always_comb begin
    cls_o   = CLS_LOGIC;
    swap_o  = 1'b0;
    use_c_o = 1'b0;
    unique case (dp_op_e'(op_i))
      OP_SUB, OP_CMP: cls_o = CLS_SUB;
      OP_RSB:         begin cls_o = CLS_SUB; swap_o = 1'b1; end
      OP_SBC:         begin cls_o = CLS_SUB; use_c_o = 1'b1; end
      OP_RSC:         begin cls_o = CLS_SUB; use_c_o = 1'b1; swap_o = 1'b1; end
      OP_ADD, OP_CMN: cls_o = CLS_ADD;
      OP_ADC:         begin cls_o = CLS_ADD; use_c_o = 1'b1; end
      default:        cls_o = CLS_LOGIC;
    endcase
    test_o = (op_i[3:2] == 2'b10);
  end
endmodule

// File: rtl/dpu_logic.sv
module dpu_logic
  import dpu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (dp_op_e'(op_i))
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_MOV:         res_o = b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/dpu_arith.sv
module dpu_arith #(
  parameter int unsigned W = 32
) (
  input  logic         sub_i,
  input  logic         swap_i,
  input  logic         use_c_i,
  input  logic         c_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int unsigned XW = W + 2;

  logic [W-1:0]  lhs, rhs;
  logic          cin;
  logic [XW-1:0] subtr;
  logic [W:0]    sum;
  logic [W-1:0]  ov_vec;

  always_comb begin
    lhs   = swap_i ? b_i : a_i;
    rhs   = swap_i ? a_i : b_i;
    cin   = use_c_i ? c_i : sub_i;
    // subtrahend = rhs - cin + 1, never negative, may reach 2^W
    subtr = {2'b00, rhs} + XW'(1) - XW'(cin);
    sum   = {1'b0, lhs} + {1'b0, rhs} + (W+1)'(cin);
    if (sub_i) begin
      res_o  = lhs - subtr[W-1:0];
      cout_o = (subtr <= {2'b00, lhs});
      ov_vec = (lhs ^ res_o) & (~rhs ^ res_o);
    end else begin
      res_o  = sum[W-1:0];
      cout_o = sum[W];
      ov_vec = (lhs ^ res_o) & (rhs ^ res_o);
    end
    ovf_o = ov_vec[W-1];
  end
endmodule

// File: rtl/dpu_exec.sv
module dpu_exec
  import dpu_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned RIDX_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [W-1:0]      opa_i,
  input  logic [W-1:0]      opb_i,
  input  logic              shc_i,
  input  logic              set_i,
  input  logic [RIDX_W-1:0] rd_i,
  input  logic [W-1:0]      saved_i,
  output logic [W-1:0]      res_o,
  output logic              wr_en_o,
  output logic              restore_o,
  output logic              refill_o,
  output logic [W-1:0]      stat_o
);
  localparam int unsigned           FL_LSB = W - 4;
  localparam logic [RIDX_W-1:0]     PC_IDX = {RIDX_W{1'b1}};

  dp_cls_e      cls;
  logic         swap, use_c, is_test;
  logic [W-1:0] log_res, ari_res, res;
  logic         ari_c, ari_v;
  nzcv_t        cur_f, nxt_f;
  logic         pc_dst, do_wr, do_rst, do_rf, do_upd;
  logic [W-1:0] stat_q, stat_d, res_q;
  logic         wr_q, rst_q, rf_q;

  assign cur_f = nzcv_t'(stat_q[W-1:FL_LSB]);

  dpu_decode i_dec (
    .op_i    (op_i),
    .cls_o   (cls),
    .swap_o  (swap),
    .use_c_o (use_c),
    .test_o  (is_test)
  );

  dpu_logic #(.W(W)) i_log (
    .op_i  (op_i),
    .a_i   (opa_i),
    .b_i   (opb_i),
    .res_o (log_res)
  );

  dpu_arith #(.W(W)) i_ari (
    .sub_i   (cls == CLS_SUB),
    .swap_i  (swap),
    .use_c_i (use_c),
    .c_i     (cur_f.c),
    .a_i     (opa_i),
    .b_i     (opb_i),
    .res_o   (ari_res),
    .cout_o  (ari_c),
    .ovf_o   (ari_v)
  );

  always_comb begin
    res    = (cls == CLS_LOGIC) ? log_res : ari_res;
    nxt_f.n = res[W-1];
    nxt_f.z = (res == '0);
    nxt_f.c = (cls == CLS_LOGIC) ? shc_i   : ari_c;
    nxt_f.v = (cls == CLS_LOGIC) ? cur_f.v : ari_v;

    pc_dst = (rd_i == PC_IDX);
    do_wr  = !is_test;
    do_rst = pc_dst && (is_test || set_i);
    do_rf  = pc_dst && !is_test;
    do_upd = !do_rst && (is_test || set_i);

    if (do_rst)      stat_d = saved_i;
    else if (do_upd) stat_d = {nxt_f, stat_q[FL_LSB-1:0]};
    else             stat_d = stat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      stat_q <= '0;
      wr_q   <= 1'b0;
      rst_q  <= 1'b0;
      rf_q   <= 1'b0;
    end else begin
      wr_q  <= valid_i && do_wr;
      rst_q <= valid_i && do_rst;
      rf_q  <= valid_i && do_rf;
      if (valid_i) begin
        res_q  <= res;
        stat_q <= stat_d;
      end
    end
  end

  assign res_o     = res_q;
  assign wr_en_o   = wr_q;
  assign restore_o = rst_q;
  assign refill_o  = rf_q;
  assign stat_o    = stat_q;
endmodule

// File: rtl/dpu_exec_chk.sv
module dpu_exec_chk #(
  parameter int unsigned W      = 32,
  parameter int unsigned RIDX_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic              set_i,
  input logic [RIDX_W-1:0] rd_i,
  input logic [W-1:0]      saved_i,
  input logic              wr_en_o,
  input logic              restore_o,
  input logic              refill_o,
  input logic [W-1:0]      stat_o
);
  logic tst, lgc, pc;
  assign tst = (op_i[3:2] == 2'b10);
  assign lgc = (op_i[3:1] == 3'b000) || (op_i[3:1] == 3'b100) || (op_i[3:2] == 2'b11);
  assign pc  = (rd_i == {RIDX_W{1'b1}});

  a_r5_test_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && tst |=> !wr_en_o);

  a_r6_logic_keeps_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && lgc && set_i && !pc |=> stat_o[W-4] == $past(stat_o[W-4]));

  a_r7_no_set_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !tst && !set_i |=> $stable(stat_o) && !restore_o);

  a_r8_restore_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && pc && !tst && set_i |=> restore_o && refill_o && wr_en_o && stat_o == $past(saved_i));

  a_r9_test_pc_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && pc && tst |=> restore_o && !refill_o && stat_o == $past(saved_i));

  a_r10_refill_on_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && pc && !tst |=> refill_o);

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !wr_en_o && !restore_o && !refill_o && $stable(stat_o));

  a_r10_refill_implies_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_o |-> wr_en_o);
endmodule

bind dpu_exec dpu_exec_chk #(.W(W), .RIDX_W(RIDX_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .set_i     (set_i),
  .rd_i      (rd_i),
  .saved_i   (saved_i),
  .wr_en_o   (wr_en_o),
  .restore_o (restore_o),
  .refill_o  (refill_o),
  .stat_o    (stat_o)
);

// File: tb/test_dpu_exec.sv
`timescale 1ns/1ps
module test_dpu_exec;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] opa_i = '0, opb_i = '0, saved_i = '0;
  logic        shc_i = 1'b0, set_i = 1'b0;
  logic [3:0]  rd_i = '0;
  logic [31:0] res_o, stat_o;
  logic        wr_en_o, restore_o, refill_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  dpu_exec i_dpu_exec (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sc, input logic s, input logic [3:0] rd, input logic [31:0] sv);
    op_i = op; opa_i = a; opb_i = b; shc_i = sc; set_i = s; rd_i = rd; saved_i = sv;
    valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [31:0] res, input logic wr,
                            input logic rs, input logic rf, input logic [31:0] st);
    chk(req, "res", res_o, res);
    chk(req, "wr", {31'b0, wr_en_o}, {31'b0, wr});
    chk(req, "restore", {31'b0, restore_o}, {31'b0, rs});
    chk(req, "refill", {31'b0, refill_o}, {31'b0, rf});
    chk(req, "stat", stat_o, st);
  endtask

  task automatic t_reset;
    expect_out("R11", 32'h0, 0, 0, 0, 32'h0);
  endtask

  task automatic t_logic;
    issue(4'hD, 32'h0, 32'h0000_1234, 0, 1, 4'hF, 32'h1000_0055);
    expect_out("R8", 32'h0000_1234, 1, 1, 1, 32'h1000_0055);
    issue(4'h0, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 1, 1, 4'h2, 32'h0);
    expect_out("R6", 32'h00F0_00F0, 1, 0, 0, 32'h3000_0055);
    issue(4'h1, 32'hFFFF_0000, 32'h0000_FFFF, 0, 1, 4'h2, 32'h0);
    expect_out("R7", 32'hFFFF_FFFF, 1, 0, 0, 32'h9000_0055);
    issue(4'hE, 32'h0000_00FF, 32'h0000_00FF, 1, 1, 4'h2, 32'h0);
    expect_out("R6", 32'h0, 1, 0, 0, 32'h7000_0055);
    issue(4'hC, 32'h1, 32'h2, 0, 0, 4'h2, 32'h0);
    expect_out("R7", 32'h3, 1, 0, 0, 32'h7000_0055);
    issue(4'hF, 32'h5, 32'h0, 0, 0, 4'h2, 32'h0);
    expect_out("R1", 32'hFFFF_FFFF, 1, 0, 0, 32'h7000_0055);
    issue(4'hD, 32'h5, 32'h0000_ABCD, 0, 0, 4'h2, 32'h0);
    expect_out("R1", 32'h0000_ABCD, 1, 0, 0, 32'h7000_0055);
  endtask

  task automatic t_add;
    issue(4'h4, 32'hFFFF_FFFF, 32'h1, 0, 1, 4'h1, 32'h0);
    expect_out("R3", 32'h0, 1, 0, 0, 32'h6000_0055);
    issue(4'h4, 32'h7FFF_FFFF, 32'h1, 0, 1, 4'h1, 32'h0);
    expect_out("R3", 32'h8000_0000, 1, 0, 0, 32'h9000_0055);
    issue(4'h4, 32'hFFFF_FFFF, 32'h1, 0, 1, 4'h1, 32'h0);
    issue(4'h5, 32'h5, 32'h6, 0, 1, 4'h1, 32'h0);
    expect_out("R3", 32'hC, 1, 0, 0, 32'h0000_0055);
    issue(4'h5, 32'h5, 32'h6, 0, 1, 4'h1, 32'h0);
    expect_out("R3", 32'hB, 1, 0, 0, 32'h0000_0055);
    issue(4'hB, 32'h8000_0000, 32'h8000_0000, 0, 0, 4'h3, 32'h0);
    expect_out("R5", 32'h0, 0, 0, 0, 32'h7000_0055);
  endtask

  task automatic t_sub;
    issue(4'h2, 32'h5, 32'h3, 0, 1, 4'h4, 32'h0);
    expect_out("R4", 32'h2, 1, 0, 0, 32'h2000_0055);
    issue(4'h2, 32'h3, 32'h5, 0, 1, 4'h4, 32'h0);
    expect_out("R4", 32'hFFFF_FFFE, 1, 0, 0, 32'h8000_0055);
    issue(4'h2, 32'h8000_0000, 32'h1, 0, 1, 4'h4, 32'h0);
    expect_out("R4", 32'h7FFF_FFFF, 1, 0, 0, 32'h3000_0055);
    issue(4'h3, 32'h5, 32'h3, 0, 1, 4'h4, 32'h0);
    expect_out("R2", 32'hFFFF_FFFE, 1, 0, 0, 32'h8000_0055);
    issue(4'h6, 32'h0, 32'hFFFF_FFFF, 0, 1, 4'h4, 32'h0);
    expect_out("R4", 32'h0, 1, 0, 0, 32'h4000_0055);
    issue(4'h6, 32'hA, 32'h3, 0, 1, 4'h4, 32'h0);
    expect_out("R4", 32'h6, 1, 0, 0, 32'h2000_0055);
    issue(4'h6, 32'hA, 32'h3, 0, 1, 4'h4, 32'h0);
    expect_out("R4", 32'h7, 1, 0, 0, 32'h2000_0055);
    issue(4'h7, 32'h3, 32'hA, 0, 1, 4'h4, 32'h0);
    expect_out("R2", 32'h7, 1, 0, 0, 32'h2000_0055);
  endtask

  task automatic t_test_ops;
    issue(4'hA, 32'h3, 32'h3, 0, 0, 4'h0, 32'h0);
    expect_out("R5", 32'h0, 0, 0, 0, 32'h6000_0055);
    issue(4'h8, 32'hF0, 32'h0F, 0, 0, 4'h0, 32'h0);
    expect_out("R5", 32'h0, 0, 0, 0, 32'h4000_0055);
    issue(4'h9, 32'h8000_0000, 32'h0, 1, 0, 4'h0, 32'h0);
    expect_out("R5", 32'h8000_0000, 0, 0, 0, 32'hA000_0055);
  endtask

  task automatic t_pc_paths;
    issue(4'hA, 32'h1, 32'h2, 0, 0, 4'hF, 32'hDEAD_BEEF);
    chk("R9", "wr", {31'b0, wr_en_o}, 32'h0);
    chk("R9", "restore", {31'b0, restore_o}, 32'h1);
    chk("R9", "refill", {31'b0, refill_o}, 32'h0);
    chk("R9", "stat", stat_o, 32'hDEAD_BEEF);
    issue(4'h4, 32'h100, 32'h4, 0, 0, 4'hF, 32'h0);
    expect_out("R10", 32'h104, 1, 0, 1, 32'hDEAD_BEEF);
    issue(4'h2, 32'h3, 32'h5, 0, 1, 4'hF, 32'h1234_5678);
    expect_out("R8", 32'hFFFF_FFFE, 1, 1, 1, 32'h1234_5678);
  endtask

  task automatic t_idle;
    opa_i = 32'hFFFF_FFFF; set_i = 1'b1; rd_i = 4'hF; saved_i = 32'h0;
    @(posedge clk_i);
    @(negedge clk_i);
    expect_out("R12", 32'hFFFF_FFFE, 0, 0, 0, 32'h1234_5678);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_logic();
    t_add();
    t_sub();
    t_test_ops();
    t_pc_paths();
    t_idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule